// File: doc/BRIEF.md
# Byte-Wide SPI Shift Port

This block is a one-byte serial port for a small controller. Software writes a byte into the transmit side through a three-address register bus. The byte goes straight into an 8-bit shift register. The shifter then waits for clock edges. It can generate them itself as master, or take them from an external master as slave. Each rising SCK edge shifts one bit in from SDI. After a programmable settling delay, the next outgoing bit appears on SDO.

When the eighth bit arrives, the assembled byte moves into a separate read buffer. A full flag and an interrupt flag are raised. The interrupt output follows that flag, but only while the interrupt enable input is high. A second byte that completes while the read buffer is still unread does not overwrite it; it sets an overrun bit instead.

Register map (byte-wide, `bus_addr`):

| Address | Read | Write |
|---|---|---|
| 0 | read buffer | no effect |
| 1 | returns 0 | write buffer |
| 2 | status | status |

Status bits: bit 7 is the order, bit 6:5 the delay code, bit 4 overrun, bit 3 the interrupt flag and bit 0 read-buffer-full. Bits 2:1 always read 0.

Top module: `spi_byte_port`

## Requirements
- R1: After reset, the status and read buffer read as 0x00, and `irq`, `sdo` and `sck_out` are 0.
- R2: A write to address 1 while `port_en` is 1 loads the shifter and puts its first bit on `sdo`. No bit is taken until a rising SCK edge arrives. The byte completes on the eighth rising edge. Without edges, nothing completes.
- R3: Status bit 7 selects the order. With 0, the MSB goes out first and SDI bits enter at the LSB end. With 1, the LSB goes out first and SDI bits enter at the MSB end.
- R4: Status bits 6:5 (code c) set the SDO delay to 8*(c+1) system clocks after each shift edge. In slave mode, the shift edge is registered 3 clocks after `sck_in` rises (two-flop synchroniser plus edge detector). Hence SDO changes 3+8*(c+1) clocks after that rise.
- R5: When a byte completes and the read buffer is empty, the byte is stored at address 0, and status bits 0 and 3 are set. A read of address 0 clears bit 0.
- R6: `irq` equals status bit 3 AND `irq_en`. Writing 0 to status bit 3 clears the flag; writing 1 leaves it unchanged.
- R7: If a byte completes while status bit 0 is set, status bit 4 is set and the read buffer keeps its old byte. Writing 0 to bit 4 clears it.
- R8: While `port_en` is 0, any transfer is aborted and the bit count is reset. `sdo` reads 0, no byte completes, and the next transfer starts again at bit 0.
- R9: With `master` at 1, `sck_out` toggles every DIV clocks during a transfer and gives exactly 8 rising edges. It is 0 when idle and always 0 in slave mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| bus_addr | input | 2 | register address |
| bus_wdata | input | 8 | write data |
| bus_wr | input | 1 | write strobe, one clock per access |
| bus_rd | input | 1 | read strobe, one clock per access |
| bus_rdata | output | 8 | read data, combinational from address |
| port_en | input | 1 | port enable; 0 aborts and idles |
| master | input | 1 | 1 = generate SCK, 0 = follow `sck_in` |
| irq_en | input | 1 | interrupt enable |
| sck_in | input | 1 | external serial clock (slave) |
| sck_out | output | 1 | generated serial clock (master) |
| sdi | input | 1 | serial data in |
| sdo | output | 1 | serial data out |
| irq | output | 1 | interrupt request |

## Verification
The properties assume the following about the inputs:
- Bus strobes last one clock and never coincide.
- In slave mode, each half period of `sck_in` is longer than the 3-clock synchroniser latency plus the longest 32-clock delay. Each bit then settles before the next rising edge.
- `sdi` is steady around the sampling edge.

The bench keeps within these limits as follows:
- It drives every bus access as a single-clock strobe.
- It holds each `sck_in` level for 40 clocks.
- It changes `sdi` only while SCK is low.
- In master mode, it changes `sdi` only on falling `sck_out`.

// File: rtl/spi_byte_port.sv
module spi_byte_port #(
  parameter int DIV = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wr,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  input  logic       port_en,
  input  logic       master,
  input  logic       irq_en,
  input  logic       sck_in,
  output logic       sck_out,
  input  logic       sdi,
  output logic       sdo,
  output logic       irq
);
  localparam int CW = $clog2(DIV + 1);
  localparam logic [CW-1:0] DLAST = CW'(DIV - 1);

  logic [7:0] rbuf, shreg;
  logic       order, ovr, iflag, rbf, busy, sdo_q, sck_q;
  logic [1:0] dsel;
  logic [2:0] bitcnt, ssync;
  logic [5:0] dly;
  logic [CW-1:0] div;

  wire sel_rb   = bus_addr == 2'd0;
  wire sel_wb   = bus_addr == 2'd1;
  wire sel_st   = bus_addr == 2'd2;
  wire rb_read  = bus_rd && sel_rb;
  wire run_clk  = master && (busy || sck_q);
  wire m_rise   = run_clk && div == DLAST && !sck_q;
  wire s_rise   = !master && ssync[1] && !ssync[2];
  wire shift_ev = busy && (m_rise || s_rise);
  wire [7:0] nxt = order ? {sdi, shreg[7:1]} : {shreg[6:0], sdi};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf <= '0; shreg <= '0; order <= 1'b0; dsel <= '0;
      ovr <= 1'b0; iflag <= 1'b0; rbf <= 1'b0; busy <= 1'b0;
      sdo_q <= 1'b0; sck_q <= 1'b0; bitcnt <= '0; ssync <= '0;
      dly <= '0; div <= '0;
    end else begin
      ssync <= {ssync[1:0], sck_in};
      if (run_clk) begin
        if (div == DLAST) begin
          div   <= '0;
          sck_q <= ~sck_q;
        end else div <= div + 1'b1;
      end else begin
        div   <= '0;
        sck_q <= 1'b0;
      end
      if (bus_wr && sel_st) begin
        order <= bus_wdata[7];
        dsel  <= bus_wdata[6:5];
        if (!bus_wdata[4]) ovr <= 1'b0;
        if (!bus_wdata[3]) iflag <= 1'b0;
      end
      if (rb_read) rbf <= 1'b0;
      if (dly != 6'd0) begin
        dly <= dly - 6'd1;
        if (dly == 6'd1) sdo_q <= order ? shreg[0] : shreg[7];
      end
      if (!port_en) begin
        busy <= 1'b0; bitcnt <= '0; dly <= '0; sdo_q <= 1'b0;
      end else if (bus_wr && sel_wb) begin
        shreg  <= bus_wdata;
        busy   <= 1'b1;
        bitcnt <= '0;
        dly    <= '0;
        sdo_q  <= order ? bus_wdata[0] : bus_wdata[7];
      end else if (shift_ev) begin
        shreg  <= nxt;
        bitcnt <= bitcnt + 3'd1;
        if (bitcnt == 3'd7) begin
          busy <= 1'b0;
          dly  <= '0;
          if (rbf && !rb_read) ovr <= 1'b1;
          else begin
            rbuf  <= nxt;
            rbf   <= 1'b1;
            iflag <= 1'b1;
          end
        end else dly <= {1'b0, dsel, 3'b000} + 6'd8;
      end
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (sel_rb) bus_rdata = rbuf;
    else if (sel_st) bus_rdata = {order, dsel, ovr, iflag, 2'b00, rbf};
  end

  assign sck_out = sck_q;
  assign sdo     = port_en & sdo_q;
  assign irq     = iflag & irq_en;
endmodule

module spi_byte_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] bus_addr,
  input logic       bus_rd,
  input logic       port_en,
  input logic       master,
  input logic       irq_en,
  input logic       irq,
  input logic       sck_out,
  input logic       busy,
  input logic       rbf,
  input logic       iflag,
  input logic [7:0] rbuf,
  input logic [2:0] bitcnt
);
  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);
  assert_flag_with_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rbf) |-> iflag);
  assert_keep_on_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rbf) && !$past(bus_rd && bus_addr == 2'd0)) |-> $stable(rbuf));
  assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !busy);
  assert_slave_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !master |=> !sck_out);
  assert_count_reset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> bitcnt == 3'd0);
endmodule

bind spi_byte_port spi_byte_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .port_en(port_en), .master(master), .irq_en(irq_en), .irq(irq),
  .sck_out(sck_out), .busy(busy), .rbf(rbf), .iflag(iflag),
  .rbuf(rbuf), .bitcnt(bitcnt)
);

// File: tb/spi_byte_port_bench.sv
`timescale 1ns/1ps
module spi_byte_port_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic port_en = 1'b0, master = 1'b0, irq_en = 1'b0;
  logic sck_in = 1'b0, sdi = 1'b0;
  logic sck_out, sdo, irq;

  int n_chk = 0, n_bad = 0, rises = 0;
  logic exp_q[$];
  bit mon_on = 1'b0;

  always #2.5 clk = ~clk;

  spi_byte_port u_spi_byte_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .port_en(port_en), .master(master), .irq_en(irq_en),
    .sck_in(sck_in), .sck_out(sck_out), .sdi(sdi), .sdo(sdo), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic bus_write(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // driver: queue the expected SDO bits, then clock a byte in as slave
  task automatic slave_xfer(logic [7:0] tx, logic [7:0] rx, bit lsb, logic [1:0] code);
    bus_write(2'd2, {lsb, code, 2'b11, 3'b000});
    for (int i = 0; i < 8; i++) exp_q.push_back(lsb ? tx[i] : tx[7-i]);
    bus_write(2'd1, tx);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      sdi = lsb ? rx[i] : rx[7-i];
      sck_in = 1'b0;
      repeat (40) @(negedge clk);
      sck_in = 1'b1;
      repeat (40) @(negedge clk);
    end
    sck_in = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  // monitor: every bit on SDO at a rising SCK must match the queue head
  always @(posedge sck_in) begin
    if (mon_on && exp_q.size() > 0) begin
      logic e;
      e = exp_q.pop_front();
      check("R2/R3 sdo bit", sdo, e);
    end
  end

  always @(posedge sck_out) rises++;

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int cnt;
    logic prev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    bus_read(2'd2, d); check("R1 status", d, 8'h00);
    bus_read(2'd0, d); check("R1 rbuf", d, 8'h00);
    check("R1 irq", irq, 0); check("R1 sdo", sdo, 0); check("R1 sck_out", sck_out, 0);

    port_en = 1'b1; mon_on = 1'b1;
    // R3 MSB first, R5 full flag, R6 gating
    slave_xfer(8'hA5, 8'h3C, 1'b0, 2'd0);
    bus_read(2'd2, d); check("R5 status after byte", d, 8'h09);
    check("R6 irq masked", irq, 0);
    irq_en = 1'b1; #1;
    check("R6 irq enabled", irq, 1);
    bus_read(2'd0, d); check("R3 msb-first rx", d, 8'h3C);
    bus_read(2'd2, d); check("R5 full cleared by read", d, 8'h08);
    bus_write(2'd2, 8'h18); #1;
    check("R6 write 1 keeps flag", irq, 1);
    bus_write(2'd2, 8'h10); #1;
    check("R6 write 0 clears flag", irq, 0);

    // R3 LSB first with delay code 2
    slave_xfer(8'hC1, 8'h5A, 1'b1, 2'd2);
    bus_read(2'd2, d); check("R3 status lsb", d, 8'hC9);
    bus_read(2'd0, d); check("R3 lsb-first rx", d, 8'h5A);
    bus_write(2'd2, 8'h00);

    // R7 overrun
    slave_xfer(8'h0F, 8'h11, 1'b0, 2'd0);
    slave_xfer(8'hF0, 8'h22, 1'b0, 2'd0);
    bus_read(2'd2, d); check("R7 overrun bit", d, 8'h19);
    bus_read(2'd0, d); check("R7 old byte kept", d, 8'h11);
    bus_write(2'd2, 8'h00);
    bus_read(2'd2, d); check("R7 overrun cleared", d, 8'h00);
    mon_on = 1'b0;

    // R4 delay for every code
    for (int c = 0; c < 4; c++) begin
      bus_write(2'd2, {1'b0, 2'(c), 5'b0});
      bus_write(2'd1, 8'h55);
      check("R4 first bit", sdo, 0);
      @(negedge clk);
      sck_in = 1'b1;
      prev = sdo; cnt = 0;
      do begin
        @(negedge clk); cnt++;
      end while (sdo == prev && cnt < 80);
      check($sformatf("R4 delay code %0d", c), cnt, 3 + 8 * (c + 1));
      repeat (5) @(negedge clk);
      sck_in = 1'b0;
      port_en = 1'b0;
      repeat (5) @(negedge clk);
      port_en = 1'b1;
    end
    bus_write(2'd2, 8'h00);

    // R2 no edges, no progress
    bus_write(2'd1, 8'h81);
    repeat (200) @(negedge clk);
    bus_read(2'd2, d); check("R2 waits for edges", d, 8'h00);
    check("R2 first bit held", sdo, 1);

    // R8 abort mid-transfer
    for (int i = 0; i < 3; i++) begin
      sck_in = 1'b1; repeat (40) @(negedge clk);
      sck_in = 1'b0; repeat (40) @(negedge clk);
    end
    port_en = 1'b0; #1;
    check("R8 sdo low", sdo, 0);
    repeat (5) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      sck_in = 1'b1; repeat (40) @(negedge clk);
      sck_in = 1'b0; repeat (40) @(negedge clk);
    end
    bus_read(2'd2, d); check("R8 no byte while off", d, 8'h00);
    port_en = 1'b1; mon_on = 1'b1;
    slave_xfer(8'h6E, 8'h96, 1'b0, 2'd1);
    bus_read(2'd0, d); check("R8 restart at bit 0", d, 8'h96);
    bus_write(2'd2, 8'h00);
    mon_on = 1'b0;

    // R9 master mode
    master = 1'b1;
    rises = 0;
    sdi = 1'b1;
    bus_write(2'd1, 8'h00);
    fork
      begin
        logic [7:0] b;
        b = 8'hA3;
        for (int i = 1; i < 8; i++) begin
          @(negedge sck_out);
          sdi = b[7-i];
        end
      end
    join_none
    repeat (400) @(negedge clk);
    check("R9 eight rising edges", rises, 8);
    check("R9 sck idle low", sck_out, 0);
    bus_read(2'd0, d); check("R9 master rx", d, 8'hA3);
    master = 1'b0;
    repeat (5) @(negedge clk);
    check("R9 slave sck_out low", sck_out, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule